// File: doc/BRIEF.md
# Host Word to Bus Byte Staging Buffer

This block stands between a 16-bit host data register and a byte-serial transfer sequencer. On the transmit side it gathers host writes into a four-byte staging word. A write is either a full 16-bit word or a single trailing byte. The sequencer then drains the staged bytes one at a time, oldest first. On the receive side it collects bytes from the bus receiver into a second four-byte staging word and hands them to the host two at a time through a 16-bit read port.

A byte-order control input selects how the two bytes of a host word map onto bus order. The block keeps a pending-byte count for each direction. Every accepted operation also produces one-cycle flag-update pulses, which the surrounding status register applies: clear transmit underflow, clear transmit-ready, set single-byte-data, clear receive-ready, end the access (set access-ready and drop master), and clear receive overrun. Mode inputs tell the block whether the controller is acting as master and whether it is transmitting.

Three data paths use valid/ready: the host write port, the receiver byte push and the transmitter byte pop. A transfer happens on a rising edge where both valid and ready are high. A host write that is offered while ready is low is dropped, not held. The receiver must keep a byte and its valid until ready is high. The transmitter may hold its ready low for any length of time, and the staged bytes stay put. The host read is a plain strobe that is never refused. Its data is the current state of the block, shown in the cycle of the strobe.

Top module: `xfer_stage_buf`

## Requirements
- R1: `wr_ready` is high exactly when at most 2 transmit bytes are pending. A write offered while `wr_ready` is low changes neither the staged bytes nor the pending count.
- R2: An accepted 16-bit write raises the transmit pending count by 2. With `order_be`=1 the high byte `wr_data[15:8]` goes onto the bus first. With `order_be`=0 the low byte `wr_data[7:0]` goes first.
- R3: An accepted byte write (`wr_byte`=1) stages `wr_data[7:0]` behind every byte already pending and raises the count by 1.
- R4: `txb_valid` is high exactly when the transmit count is nonzero. `txb_data` is the oldest pending byte. A pop (`txb_valid` and `txb_ready`) lowers the count by 1. A pop and a write in the same cycle both take effect.
- R5: Each accepted write pulses `flag_upd[0]` (clear underflow) in the next cycle. It also pulses `flag_upd[1]` (clear transmit-ready) if more than 2 bytes are pending after that edge.
- R6: `rxb_ready` is high exactly when fewer than 4 receive bytes are pending. A pushed byte is stored at byte lane (pending count), so the first byte received is read back in `rd_data[7:0]` when `order_be`=0. In a cycle with a host read, the push is applied after the read.
- R7: `rd_data` is the low halfword of the receive staging word, byte-swapped when `order_be`=1 and unswapped when it is 0.
- R8: A read with 1 byte pending empties the buffer and pulses `flag_upd[2]` (single-byte-data). A read with 2 pending empties it. A read with 3 or 4 pending drops 2 bytes and brings the upper halfword down. A read with 0 pending changes no count.
- R9: A read that leaves the receive count at 0 pulses `flag_upd[3]` (clear receive-ready). If `mode_master`=1 and `mode_transmit`=0, it also pulses `flag_upd[4]` (end access).
- R10: Every host read pulses `flag_upd[5]` (clear overrun) in the next cycle.
- R11: After reset both counts are 0, all flag updates are 0, `txb_valid` is 0, and `wr_ready` and `rxb_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_be | input | 1 | Byte-order control for host words |
| mode_master | input | 1 | Controller is bus master |
| mode_transmit | input | 1 | Controller is transmitting |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write can be accepted |
| wr_byte | input | 1 | Write carries a single trailing byte |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Host read data |
| rxb_valid | input | 1 | Receiver byte offered |
| rxb_ready | output | 1 | Receive staging has room |
| rxb_data | input | 8 | Received byte |
| txb_valid | output | 1 | A staged byte is available |
| txb_ready | input | 1 | Transmitter takes the byte |
| txb_data | output | 8 | Next byte to send |
| tx_pending | output | 3 | Transmit bytes pending |
| rx_pending | output | 3 | Receive bytes pending |
| flag_upd | output | 6 | One-cycle status update pulses, bit map as in R5, R8, R9, R10 |

## Verification
`rd_data`, `txb_data`, `txb_valid`, `wr_ready` and `rxb_ready` are combinational views of the stored state. They are due in the same cycle as the state they describe. The pending counts and every `flag_upd` pulse come from the rising edge that accepts the operation, one edge after the stimulus is presented. The bench changes inputs 1 ns after a rising edge and compares every output at the following falling edge against a model that it advances at that same rising edge. A pulse is therefore always compared in the cycle right after its cause.

// File: rtl/xfer_stage_pkg.sv
package xfer_stage_pkg;

  localparam int FLG_W = 6;

  // Bit 0 is the first member listed last (packed struct, MSB first).
  typedef struct packed {
    logic overrun_clr;      // bit 5
    logic access_end;       // bit 4
    logic rx_ready_clr;     // bit 3
    logic single_byte_set;  // bit 2
    logic tx_ready_clr;     // bit 1
    logic underflow_clr;    // bit 0
  } flag_upd_t;

endpackage

// File: rtl/xfer_tx_packer.sv
module xfer_tx_packer #(
  parameter int BYTE_W      = 8,
  parameter int HOST_BYTES  = 2,
  parameter int STAGE_BYTES = 4,
  parameter int LEN_W       = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           order_be,
  input  logic                           wr_valid,
  input  logic                           wr_byte,
  input  logic [BYTE_W*HOST_BYTES-1:0]   wr_data,
  output logic                           wr_ready,
  output logic                           wr_accept,
  input  logic                           pop_ready,
  output logic                           pop_valid,
  output logic [BYTE_W-1:0]              pop_data,
  output logic [LEN_W-1:0]               len_q,
  output logic [LEN_W-1:0]               len_d
);

  localparam int HOST_W  = BYTE_W * HOST_BYTES;
  localparam int STAGE_W = BYTE_W * STAGE_BYTES;
  localparam logic [LEN_W-1:0] ACCEPT_MAX = LEN_W'(STAGE_BYTES - HOST_BYTES);
  localparam logic [LEN_W-1:0] HOST_LEN   = LEN_W'(HOST_BYTES);
  localparam logic [LEN_W-1:0] ONE        = LEN_W'(1);

  logic [STAGE_W-1:0] word_q, word_d;
  logic [HOST_W-1:0]  swapped;
  logic [HOST_W-1:0]  ins_half;
  logic               pop;

  // byte reversal of the host word
  for (genvar g = 0; g < HOST_BYTES; g++) begin : g_swap
    assign swapped[g*BYTE_W +: BYTE_W] = wr_data[(HOST_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  assign ins_half  = order_be ? wr_data : swapped;
  assign wr_ready  = (len_q <= ACCEPT_MAX);
  assign wr_accept = wr_valid && wr_ready;
  assign pop_valid = (len_q != '0);
  assign pop       = pop_valid && pop_ready;

  always_comb begin
    word_d = word_q;
    len_d  = len_q;
    if (wr_accept) begin
      if (wr_byte) begin
        word_d = {word_q[STAGE_W-BYTE_W-1:0], wr_data[BYTE_W-1:0]};
        len_d  = len_q + ONE;
      end else begin
        word_d = {word_q[STAGE_W-HOST_W-1:0], ins_half};
        len_d  = len_q + HOST_LEN;
      end
    end
    if (pop) begin
      len_d = len_d - ONE;
    end
  end

  // oldest pending byte sits in lane (count - 1)
  always_comb begin
    pop_data = '0;
    for (int i = 0; i < STAGE_BYTES; i++) begin
      if (len_q == LEN_W'(i + 1)) begin
        pop_data = word_q[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      len_q  <= '0;
    end else begin
      word_q <= word_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/xfer_rx_unpacker.sv
module xfer_rx_unpacker #(
  parameter int BYTE_W      = 8,
  parameter int HOST_BYTES  = 2,
  parameter int STAGE_BYTES = 4,
  parameter int LEN_W       = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           order_be,
  input  logic                           rd_en,
  output logic [BYTE_W*HOST_BYTES-1:0]   rd_data,
  input  logic                           push_valid,
  input  logic [BYTE_W-1:0]              push_data,
  output logic                           push_ready,
  output logic [LEN_W-1:0]               len_q,
  output logic                           rd_single,
  output logic                           rd_leaves_empty
);

  localparam int HOST_W  = BYTE_W * HOST_BYTES;
  localparam int STAGE_W = BYTE_W * STAGE_BYTES;
  localparam logic [LEN_W-1:0] HOST_LEN  = LEN_W'(HOST_BYTES);
  localparam logic [LEN_W-1:0] STAGE_LEN = LEN_W'(STAGE_BYTES);
  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

  logic [STAGE_W-1:0] word_q, word_r, word_d;
  logic [LEN_W-1:0]   len_r, len_d;
  logic [HOST_W-1:0]  low_half, low_swapped;

  assign low_half = word_q[HOST_W-1:0];

  for (genvar g = 0; g < HOST_BYTES; g++) begin : g_swap
    assign low_swapped[g*BYTE_W +: BYTE_W] = low_half[(HOST_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  assign rd_data    = order_be ? low_swapped : low_half;
  assign push_ready = (len_q < STAGE_LEN);
  assign rd_single  = rd_en && (len_q == ONE);

  // host read consumes first
  always_comb begin
    word_r = word_q;
    len_r  = len_q;
    if (rd_en) begin
      if (len_q > HOST_LEN) begin
        word_r = word_q >> HOST_W;
        len_r  = len_q - HOST_LEN;
      end else begin
        len_r  = '0;
      end
    end
  end

  assign rd_leaves_empty = rd_en && (len_r == '0);

  // then a received byte lands in the first free lane
  always_comb begin
    word_d = word_r;
    len_d  = len_r;
    if (push_valid && push_ready) begin
      for (int i = 0; i < STAGE_BYTES; i++) begin
        if (len_r == LEN_W'(i)) begin
          word_d[i*BYTE_W +: BYTE_W] = push_data;
        end
      end
      len_d = len_r + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      len_q  <= '0;
    end else begin
      word_q <= word_d;
      len_q  <= len_d;
    end
  end

endmodule

// File: rtl/xfer_flag_gen.sv
module xfer_flag_gen
  import xfer_stage_pkg::*;
#(
  parameter int HOST_BYTES  = 2,
  parameter int STAGE_BYTES = 4,
  parameter int LEN_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_master,
  input  logic             mode_transmit,
  input  logic             wr_accept,
  input  logic [LEN_W-1:0] tx_len_d,
  input  logic             rd_en,
  input  logic             rd_single,
  input  logic             rd_leaves_empty,
  output flag_upd_t        flags_q
);

  localparam logic [LEN_W-1:0] TX_FULLISH = LEN_W'(STAGE_BYTES - HOST_BYTES);

  flag_upd_t flags_d;

  always_comb begin
    flags_d                 = '0;
    flags_d.underflow_clr   = wr_accept;
    flags_d.tx_ready_clr    = wr_accept && (tx_len_d > TX_FULLISH);
    flags_d.single_byte_set = rd_single;
    flags_d.rx_ready_clr    = rd_leaves_empty;
    flags_d.access_end      = rd_leaves_empty && mode_master && !mode_transmit;
    flags_d.overrun_clr     = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/xfer_stage_buf.sv
module xfer_stage_buf
  import xfer_stage_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int HOST_BYTES  = 2,
  parameter int STAGE_BYTES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  order_be,
  input  logic                                  mode_master,
  input  logic                                  mode_transmit,
  input  logic                                  wr_valid,
  output logic                                  wr_ready,
  input  logic                                  wr_byte,
  input  logic [BYTE_W*HOST_BYTES-1:0]          wr_data,
  input  logic                                  rd_en,
  output logic [BYTE_W*HOST_BYTES-1:0]          rd_data,
  input  logic                                  rxb_valid,
  output logic                                  rxb_ready,
  input  logic [BYTE_W-1:0]                     rxb_data,
  output logic                                  txb_valid,
  input  logic                                  txb_ready,
  output logic [BYTE_W-1:0]                     txb_data,
  output logic [$clog2(STAGE_BYTES+1)-1:0]      tx_pending,
  output logic [$clog2(STAGE_BYTES+1)-1:0]      rx_pending,
  output logic [FLG_W-1:0]                      flag_upd
);

  localparam int LEN_W = $clog2(STAGE_BYTES + 1);

  logic             wr_accept;
  logic [LEN_W-1:0] tx_len_d;
  logic             rd_single;
  logic             rd_leaves_empty;
  flag_upd_t        flags_q;

  xfer_tx_packer #(
    .BYTE_W(BYTE_W), .HOST_BYTES(HOST_BYTES),
    .STAGE_BYTES(STAGE_BYTES), .LEN_W(LEN_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .order_be  (order_be),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .wr_accept (wr_accept),
    .pop_ready (txb_ready),
    .pop_valid (txb_valid),
    .pop_data  (txb_data),
    .len_q     (tx_pending),
    .len_d     (tx_len_d)
  );

  xfer_rx_unpacker #(
    .BYTE_W(BYTE_W), .HOST_BYTES(HOST_BYTES),
    .STAGE_BYTES(STAGE_BYTES), .LEN_W(LEN_W)
  ) u_rx (
    .clk             (clk),
    .rst_n           (rst_n),
    .order_be        (order_be),
    .rd_en           (rd_en),
    .rd_data         (rd_data),
    .push_valid      (rxb_valid),
    .push_data       (rxb_data),
    .push_ready      (rxb_ready),
    .len_q           (rx_pending),
    .rd_single       (rd_single),
    .rd_leaves_empty (rd_leaves_empty)
  );

  xfer_flag_gen #(
    .HOST_BYTES(HOST_BYTES), .STAGE_BYTES(STAGE_BYTES), .LEN_W(LEN_W)
  ) u_flags (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_master     (mode_master),
    .mode_transmit   (mode_transmit),
    .wr_accept       (wr_accept),
    .tx_len_d        (tx_len_d),
    .rd_en           (rd_en),
    .rd_single       (rd_single),
    .rd_leaves_empty (rd_leaves_empty),
    .flags_q         (flags_q)
  );

  assign flag_upd = flags_q;

endmodule

// File: rtl/xfer_stage_buf_chk.sv
module xfer_stage_buf_chk #(
  parameter int STAGE_BYTES = 4,
  parameter int LEN_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_byte,
  input logic             rd_en,
  input logic             rxb_valid,
  input logic             rxb_ready,
  input logic             txb_valid,
  input logic             txb_ready,
  input logic [LEN_W-1:0] tx_pending,
  input logic [LEN_W-1:0] rx_pending,
  input logic [5:0]       flag_upd
);

  localparam logic [LEN_W-1:0] LMAX = LEN_W'(STAGE_BYTES);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO  = LEN_W'(2);

  p_pend_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pending <= LMAX) && (rx_pending <= LMAX));

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !(txb_valid && txb_ready)) |=> (tx_pending == $past(tx_pending)));

  p_word_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_byte && !(txb_valid && txb_ready)) |=> (tx_pending == $past(tx_pending) + TWO));

  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txb_valid && txb_ready && !wr_valid) |=> (tx_pending == $past(tx_pending) - ONE));

  p_underflow_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> flag_upd[0]);

  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxb_valid && rxb_ready && !rd_en) |=> (rx_pending == $past(rx_pending) + ONE));

  p_single_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rx_pending == ONE) && !rxb_valid) |=> (flag_upd[2] && (rx_pending == '0)));

  p_access_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd[4] |-> flag_upd[3]);

  p_overrun_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> flag_upd[5]);

endmodule

bind xfer_stage_buf xfer_stage_buf_chk #(.STAGE_BYTES(STAGE_BYTES), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/xfer_stage_buf_test.sv
`timescale 1ns/1ps
module xfer_stage_buf_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        order_be, mode_master, mode_transmit;
  logic        wr_valid, wr_byte, rd_en, rxb_valid, txb_ready;
  logic [15:0] wr_data;
  logic [7:0]  rxb_data;
  logic        wr_ready, rxb_ready, txb_valid;
  logic [15:0] rd_data;
  logic [7:0]  txb_data;
  logic [2:0]  tx_pending, rx_pending;
  logic [5:0]  flag_upd;

  xfer_stage_buf uut (
    .clk(clk), .rst_n(rst_n), .order_be(order_be), .mode_master(mode_master),
    .mode_transmit(mode_transmit), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_byte(wr_byte), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rxb_valid(rxb_valid), .rxb_ready(rxb_ready), .rxb_data(rxb_data),
    .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data),
    .tx_pending(tx_pending), .rx_pending(rx_pending), .flag_upd(flag_upd)
  );

  always #2.5 clk = ~clk;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  logic [31:0] m_tx, m_rx;
  int          m_tl, m_rl;
  logic [5:0]  m_flg;
  logic [31:0] lf = 32'hACE1_2468;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] swap16(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic check_outputs();
    chk("R1 wr_ready", wr_ready, m_tl <= 2);
    chk("R4 txb_valid", txb_valid, m_tl != 0);
    if (m_tl != 0) chk("R4 txb_data", txb_data, (m_tx >> (8 * (m_tl - 1))) & 32'hff);
    chk("R2 tx_pending", tx_pending, m_tl);
    chk("R6 rxb_ready", rxb_ready, m_rl < 4);
    chk("R8 rx_pending", rx_pending, m_rl);
    chk("R7 rd_data", rd_data, order_be ? swap16(m_rx[15:0]) : m_rx[15:0]);
    chk("R5 write flag pulses", flag_upd[1:0], m_flg[1:0]);
    chk("R8 single-byte pulse", flag_upd[2], m_flg[2]);
    chk("R9 empty/access pulses", flag_upd[4:3], m_flg[4:3]);
    chk("R10 overrun clear pulse", flag_upd[5], m_flg[5]);
  endtask

  task automatic model_update();
    int ntl, acc, rr, nrl;
    logic [31:0] ntx, w1;
    acc = (wr_valid && m_tl <= 2) ? 1 : 0;
    ntl = m_tl;
    ntx = m_tx;
    if (acc != 0) begin
      if (wr_byte) begin ntx = (m_tx << 8) | {24'b0, wr_data[7:0]}; ntl = ntl + 1; end
      else begin ntx = (m_tx << 16) | {16'b0, (order_be ? wr_data : swap16(wr_data))}; ntl = ntl + 2; end
    end
    if (m_tl != 0 && txb_ready) ntl = ntl - 1;
    rr = m_rl;
    w1 = m_rx;
    if (rd_en) begin
      if (m_rl > 2) begin w1 = m_rx >> 16; rr = m_rl - 2; end
      else rr = 0;
    end
    nrl = rr;
    if (rxb_valid && m_rl < 4) begin
      w1 = (w1 & ~(32'hff << (8 * rr))) | ({24'b0, rxb_data} << (8 * rr));
      nrl = rr + 1;
    end
    m_flg[0] = (acc != 0);
    m_flg[1] = (acc != 0) && (ntl > 2);
    m_flg[2] = rd_en && (m_rl == 1);
    m_flg[3] = rd_en && (rr == 0);
    m_flg[4] = rd_en && (rr == 0) && mode_master && !mode_transmit;
    m_flg[5] = rd_en;
    m_tx = ntx; m_tl = ntl; m_rx = w1; m_rl = nrl;
  endtask

  task automatic sample();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic advance();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic idle_inputs();
    wr_valid = 0; wr_byte = 0; wr_data = '0; rd_en = 0;
    rxb_valid = 0; rxb_data = '0; txb_ready = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    #(5.0 * 60000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_b [4];
    rst_n = 0;
    order_be = 0; mode_master = 0; mode_transmit = 0;
    idle_inputs();
    m_tx = '0; m_rx = '0; m_tl = 0; m_rl = 0; m_flg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 tx_pending", tx_pending, 0);
    chk("R11 rx_pending", rx_pending, 0);
    chk("R11 flag_upd", flag_upd, 0);
    chk("R11 txb_valid", txb_valid, 0);
    chk("R11 wr_ready", wr_ready, 1);
    chk("R11 rxb_ready", rxb_ready, 1);
    @(posedge clk); #1 rst_n = 1;

    // R3: word then trailing byte, high byte first
    order_be = 1;
    wr_valid = 1; wr_byte = 0; wr_data = 16'h1234; sample(); advance();
    wr_byte = 1; wr_data = 16'h0056; sample(); advance();
    idle_inputs(); txb_ready = 1;
    exp_b[0] = 8'h12; exp_b[1] = 8'h34; exp_b[2] = 8'h56;
    for (int k = 0; k < 3; k++) begin
      sample(); chk("R3 byte order after trailing byte", txb_data, exp_b[k]); advance();
    end
    idle_inputs();

    // R1: fill four bytes, then a rejected write
    order_be = 0;
    wr_valid = 1; wr_data = 16'hA1B2; sample(); advance();
    wr_data = 16'hC3D4; sample(); advance();
    wr_data = 16'hFFFF; sample(); chk("R1 ready low when full", wr_ready, 0); advance();
    idle_inputs(); txb_ready = 1;
    exp_b[0] = 8'hB2; exp_b[1] = 8'hA1; exp_b[2] = 8'hD4; exp_b[3] = 8'hC3;
    for (int k = 0; k < 4; k++) begin
      sample(); chk("R1 rejected write left bytes intact", txb_data, exp_b[k]); advance();
    end
    sample(); chk("R1 nothing extra staged", txb_valid, 0); advance();
    idle_inputs();

    // R6 / R7 / R9: two received bytes, read in master receive
    rxb_valid = 1; rxb_data = 8'h11; sample(); advance();
    rxb_data = 8'h22; sample(); advance();
    idle_inputs();
    sample(); chk("R6 first byte in low lane", rd_data, 16'h2211); advance();
    order_be = 1; mode_master = 1; mode_transmit = 0; rd_en = 1;
    sample(); chk("R7 swapped read", rd_data, 16'h1122); advance();
    rd_en = 0;
    sample(); chk("R9 access end on empty read", flag_upd[4], 1); advance();

    // sweeps over every byte-order and mode combination
    for (int cfg = 0; cfg < 8; cfg++) begin
      order_be = cfg[0]; mode_master = cfg[1]; mode_transmit = cfg[2];
      for (int n = 0; n < 400; n++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        wr_valid  = lf[0] & lf[1];
        wr_byte   = lf[2] & lf[3] & lf[4];
        wr_data   = lf[31:16];
        txb_ready = lf[5];
        rxb_valid = lf[6];
        rxb_data  = lf[15:8];
        rd_en     = lf[7] & lf[8];
        sample();
        advance();
      end
    end
    idle_inputs();
    sample();

    done = 1;
    summary();
    $finish;
  end

endmodule